// File: doc/BRIEF.md
# Configurable Serial Peripheral Interface Controller

This block is a byte-wide SPI peripheral that sits on a small register bus. Software picks, at run time, whether the block drives the serial clock (master) or follows an external one (slave), which bit of the byte leaves first, the level the clock rests at between transfers, the clock edge that samples data, and, in master mode, one of four clock rates derived from the system clock. A write to the data register starts a master transfer. A completion flag and an interrupt request signal the end of each byte.

In slave mode the block shifts on an external clock while its select input is held low. In master mode, a low level on the select input is taken as a sign that another master holds the bus. The block then drops back to slave mode by itself and raises the completion flag, so software can react.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, `sck_o` is low and `irq` is low.
- R2: The control register at address 0 keeps all eight bits as written. Bit 7 is interrupt enable, bit 6 is block enable, bit 5 is LSB-first order, bit 4 is master role, bit 3 is clock polarity, bit 2 is clock phase, and bits 1:0 are rate select.
- R3: While bit 6 is 0, a write to the data register (address 2) starts nothing. `sck_o` does not toggle and the completion flag stays 0.
- R4: With bit 5 set to 1 the byte moves least significant bit first, and with it set to 0 most significant bit first. This holds for the bits sent on `sdo` and for the bits assembled from `sdi`.
- R5: Outside a transfer, `sck_o` rests at the level of bit 3.
- R6: With bit 2 set to 0, data is sampled on the leading clock edge and changed on the trailing edge. With bit 2 set to 1, data is changed on the leading edge and sampled on the trailing edge.
- R7: In master mode the SCK period is 4, 16, 64 or 128 system clocks for rate select 0, 1, 2 or 3.
- R8: Once the eighth bit has been sampled, status bit 7 (the completion flag) is 1 and the data register (address 2) returns the received byte.
- R9: The completion flag is cleared by a read of status (address 1) that sees it set, followed by an access to the data register.
- R10: `irq` is 1 exactly when the interrupt enable bit, the completion flag and `gie` are all 1.
- R11: If `ss_n` is low while bits 6 and 4 are both 1, the hardware clears bit 4, sets the completion flag and ends any transfer in progress.
- R12: In slave mode the block shifts on `sck_i` only while `ss_n` is low. Clock edges seen while `ss_n` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| ss_n | input | 1 | Active-low select input |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The bench builds the block with its default parameters: an 8-bit word and two synchronizer stages on `sck_i` and `ss_n`. At 8 bits, a single vector table of control bytes can cover every combination of phase, polarity and bit order used. It can also reach all four dividers, up to the slowest one at 128 clocks, well within the run limit. The two synchronizer stages set the delay between a slave clock edge and the shift. The bench holds each slave half-period at 8 clocks, so every sampled bit lands in a window where the input is stable.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef struct packed {
    logic       irq_en;
    logic       en;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  localparam int          ADDR_W    = 2;
  localparam int          HALF_W    = 7;
  localparam logic [1:0]  ADDR_CTRL = 2'd0;
  localparam logic [1:0]  ADDR_STAT = 2'd1;
  localparam logic [1:0]  ADDR_DATA = 2'd2;

  // SCK half period in system clocks for a rate select value
  function automatic logic [HALF_W-1:0] half_period(input logic [1:0] sel);
    logic [HALF_W-1:0] h;
    if (sel == 2'd3) h = HALF_W'(64);
    else             h = HALF_W'(2) << (2 * sel);
    return h;
  endfunction

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);

  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              at_end;

  always_comb begin
    at_end = (cnt_q == half_period(rate) - HALF_W'(1));
    if (!run)        cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + HALF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run & at_end;

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              clr_cnt,
  input  logic              lsb_first,
  input  logic              cpha,
  input  logic              lead,
  input  logic              trail,
  input  logic              sdi,
  output logic              sdo,
  output logic              done,
  output logic [DATA_W-1:0] word_next
);

  localparam int                CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sreg_q, sreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cap_q, cap_d;
  logic              cap_ev, shift_ev, bit_in;

  always_comb begin
    cap_ev    = cpha ? trail : lead;
    shift_ev  = cpha ? (lead && (cnt_q != '0)) : trail;
    bit_in    = cap_ev ? sdi : cap_q;
    word_next = lsb_first ? {bit_in, sreg_q[DATA_W-1:1]}
                          : {sreg_q[DATA_W-2:0], bit_in};
    done      = trail && (cnt_q == LAST);

    sreg_d = sreg_q;
    if (load)          sreg_d = load_data;
    else if (shift_ev) sreg_d = word_next;

    cap_d = cap_ev ? sdi : cap_q;

    cnt_d = cnt_q;
    if (clr_cnt || load) cnt_d = '0;
    else if (trail)      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      cap_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      cap_q  <= cap_d;
    end
  end

  assign sdo = lsb_first ? sreg_q[0] : sreg_q[DATA_W-1];

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              gie,
  output logic              irq,
  output logic              sck_o,
  input  logic              sck_i,
  input  logic              ss_n,
  input  logic              sdi,
  output logic              sdo
);

  logic [1:0]        rst_pipe_q;
  logic              rst_n_i;
  logic [SYNC_N-1:0] sck_pipe_q, ss_pipe_q;
  logic              sck_s, ss_s;

  ctrl_t             ctrl_q, ctrl_d;
  logic              flag_q, flag_d, arm_q, arm_d, busy_q, busy_d;
  logic              lvl_q, lvl_d, slv_prev_q;
  logic [DATA_W-1:0] rx_q, rx_d;

  logic wr_ctrl, wr_data, rd_stat, data_acc;
  logic master_act, slave_act, fault, start, load, tick;
  logic slv_lvl, lead, trail, core_done;
  logic [DATA_W-1:0] word_next;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sck_pipe_q <= '0;
      ss_pipe_q  <= '1;
    end else begin
      sck_pipe_q <= {sck_pipe_q[SYNC_N-2:0], sck_i};
      ss_pipe_q  <= {ss_pipe_q[SYNC_N-2:0], ss_n};
    end
  end
  assign sck_s = sck_pipe_q[SYNC_N-1];
  assign ss_s  = ss_pipe_q[SYNC_N-1];

  always_comb begin
    wr_ctrl    = bus_en && bus_we && (bus_addr == ADDR_CTRL);
    wr_data    = bus_en && bus_we && (bus_addr == ADDR_DATA);
    rd_stat    = bus_en && !bus_we && (bus_addr == ADDR_STAT);
    data_acc   = bus_en && (bus_addr == ADDR_DATA);
    master_act = ctrl_q.en && ctrl_q.master;
    slave_act  = ctrl_q.en && !ctrl_q.master && !ss_s;
    fault      = master_act && !ss_s;
    start      = wr_data && master_act && !busy_q && !fault;
    load       = wr_data && ctrl_q.en && !busy_q && !fault;
    slv_lvl    = sck_s ^ ctrl_q.cpol;
    lead       = (tick && !lvl_q) || (slave_act && slv_lvl && !slv_prev_q);
    trail      = (tick && lvl_q) || (slave_act && !slv_lvl && slv_prev_q);
  end

  spi_rate_gen u_rate (
    .clk   (clk),
    .rst_n (rst_n_i),
    .run   (busy_q),
    .rate  (ctrl_q.rate),
    .tick  (tick)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .load      (load),
    .load_data (bus_wdata),
    .clr_cnt   (!busy_q && !slave_act),
    .lsb_first (ctrl_q.lsb_first),
    .cpha      (ctrl_q.cpha),
    .lead      (lead),
    .trail     (trail),
    .sdi       (sdi),
    .sdo       (sdo),
    .done      (core_done),
    .word_next (word_next)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(bus_wdata);
    if (fault)   ctrl_d.master = 1'b0;

    busy_d = busy_q;
    if (fault || !ctrl_q.en)   busy_d = 1'b0;
    else if (start)            busy_d = 1'b1;
    else if (core_done)        busy_d = 1'b0;

    lvl_d = lvl_q;
    if (!busy_q || fault) lvl_d = 1'b0;
    else if (tick)        lvl_d = !lvl_q;

    arm_d = arm_q;
    if (data_acc)               arm_d = 1'b0;
    else if (rd_stat && flag_q) arm_d = 1'b1;

    flag_d = flag_q;
    if (core_done || fault)     flag_d = 1'b1;
    else if (data_acc && arm_q) flag_d = 1'b0;

    rx_d = core_done ? word_next : rx_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ctrl_q     <= '0;
      busy_q     <= 1'b0;
      lvl_q      <= 1'b0;
      arm_q      <= 1'b0;
      flag_q     <= 1'b0;
      rx_q       <= '0;
      slv_prev_q <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      busy_q     <= busy_d;
      lvl_q      <= lvl_d;
      arm_q      <= arm_d;
      flag_q     <= flag_d;
      rx_q       <= rx_d;
      slv_prev_q <= slv_lvl;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = ctrl_q;
      ADDR_STAT: bus_rdata = {flag_q, {(DATA_W-1){1'b0}}};
      ADDR_DATA: bus_rdata = rx_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign sck_o = lvl_q ^ ctrl_q.cpol;
  assign irq   = ctrl_q.irq_en && flag_q && gie;

endmodule

// File: rtl/spi_port_checker.sv
module spi_port_checker
  import spi_port_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input ctrl_t ctrl_q,
  input logic  flag_q,
  input logic  busy_q,
  input logic  sck_o,
  input logic  ss_s,
  input logic  irq,
  input logic  gie,
  input logic  core_done
);

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (sck_o == ctrl_q.cpol));

  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |=> !busy_q);

  assert_done_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> flag_q);

  assert_irq_gating_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q && gie && ctrl_q.irq_en));

  assert_mode_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.en && ctrl_q.master && !ss_s) |=> (!ctrl_q.master && flag_q && !busy_q));

endmodule

bind spi_port spi_port_checker u_chk (.*);

// File: tb/spi_port_bench.sv
`timescale 1ns/1ps
module spi_port_bench;

  logic       clk = 1'b0;
  logic       rst_n, bus_en, bus_we, gie, sck_i, ss_n, sdi;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq, sck_o, sdo;

  always #2.5 clk = ~clk;

  spi_port u_spi_port (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gie(gie), .irq(irq), .sck_o(sck_o), .sck_i(sck_i), .ss_n(ss_n),
    .sdi(sdi), .sdo(sdo)
  );

  int          checks = 0, fails = 0;
  int unsigned cyc = 0;
  bit          finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // control byte, byte sent by the block, byte returned by the bench
  localparam logic [23:0] VEC [6] = '{
    {8'h50, 8'hA5, 8'h3C},
    {8'h54, 8'h81, 8'h7E},
    {8'h58, 8'h96, 8'h01},
    {8'h5D, 8'hC3, 8'h5A},
    {8'h72, 8'h1E, 8'h80},
    {8'hF7, 8'h6B, 8'hD4}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  function automatic int bpos(input bit lsb, input int k);
    return lsb ? k : 7 - k;
  endfunction

  task automatic master_xfer(input logic [7:0] c, input logic [7:0] tx, input logic [7:0] rep);
    bit   cp  = c[3];
    bit   ph  = c[2];
    bit   lsb = c[5];
    int   exp_per = (c[1:0] == 2'd3) ? 128 : (4 << (2 * c[1:0]));
    int   k = 0, guard = 0, per = 0;
    longint t0 = -1;
    logic prev, cur;
    logic [7:0] got = 0, r;
    wr(2'd0, c);
    check("R5 idle level", sck_o, cp);
    sdi = ph ? 1'b0 : rep[bpos(lsb, 0)];
    wr(2'd2, tx);
    prev = cp;
    while (k < 8 && guard < 5000) begin
      @(negedge clk);
      guard++;
      cur = sck_o;
      if (prev == cp && cur != cp) begin
        if (t0 < 0) t0 = cyc; else if (per == 0) per = int'(cyc - t0);
        if (!ph) got[bpos(lsb, k)] = sdo;
        else     sdi = rep[bpos(lsb, k)];
      end else if (prev != cp && cur == cp) begin
        if (!ph) begin
          k++;
          if (k < 8) sdi = rep[bpos(lsb, k)];
        end else begin
          got[bpos(lsb, k)] = sdo;
          k++;
        end
      end
      prev = cur;
    end
    repeat (2) @(negedge clk);
    check("R7 sck period", per, exp_per);
    check("R4/R6 bits sent on sdo", got, tx);
    check("R5 idle after transfer", sck_o, cp);
    check("R10 irq with flag set", irq, c[7]);
    rd(2'd1, r);
    check("R8 completion flag", r, 8'h80);
    rd(2'd2, r);
    check("R8/R4 received byte", r, rep);
    rd(2'd1, r);
    check("R9 flag cleared", r, 8'h00);
    check("R10 irq after clear", irq, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, got;
    bit toggled;
    rst_n = 0; bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    gie = 1; sck_i = 0; ss_n = 1; sdi = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, r); check("R1 control reset", r, 8'h00);
    rd(2'd1, r); check("R1 status reset", r, 8'h00);
    check("R1 sck reset", sck_o, 1'b0);
    check("R1 irq reset", irq, 1'b0);

    // R2 register read back
    wr(2'd0, 8'hAB); rd(2'd0, r); check("R2 control read back", r, 8'hAB);
    wr(2'd0, 8'h00);

    // main table
    for (int i = 0; i < 6; i++) master_xfer(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);

    // R3 disabled: no clock, no flag
    wr(2'd0, 8'h10);
    wr(2'd2, 8'hFF);
    toggled = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sck_o !== 1'b0) toggled = 1;
    end
    check("R3 no sck while disabled", toggled, 1'b0);
    rd(2'd1, r); check("R3 no flag while disabled", r, 8'h00);

    // R11 mode fault
    wr(2'd0, 8'h50);
    ss_n = 0;
    repeat (6) @(negedge clk);
    rd(2'd0, r); check("R11 master bit cleared", r, 8'h40);
    rd(2'd1, r); check("R11 flag set", r, 8'h80);
    ss_n = 1;
    rd(2'd2, r);
    rd(2'd1, r); check("R9 flag cleared after fault", r, 8'h00);

    // R12 slave: clock ignored while not selected
    wr(2'd0, 8'h40);
    wr(2'd2, 8'h2D);
    for (int i = 0; i < 8; i++) begin
      repeat (8) @(negedge clk); sck_i = 1;
      repeat (8) @(negedge clk); sck_i = 0;
    end
    repeat (6) @(negedge clk);
    rd(2'd1, r); check("R12 edges ignored while deselected", r, 8'h00);

    // R12 slave transfer, mode 0, MSB first
    ss_n = 0;
    got = 0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      sdi = r[0];
      sdi = 8'hB2 >> (7 - k);
      repeat (6) @(negedge clk);
      got[7 - k] = sdo;
      repeat (2) @(negedge clk); sck_i = 1;
      repeat (8) @(negedge clk); sck_i = 0;
    end
    repeat (8) @(negedge clk);
    ss_n = 1;
    check("R12 slave sent byte", got, 8'h2D);
    rd(2'd1, r); check("R12/R8 slave flag", r, 8'h80);
    rd(2'd2, r); check("R12 slave received byte", r, 8'hB2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule